// File: doc/BRIEF.md
# Composite Sync Vertical Pulse Separator

This block recovers the vertical sync from a composite sync stream that runs on the pixel clock. The composite input arrives already normalised so that its active level is high. Line sync pulses in that stream are short, and the frame sync interval is long. The block measures how many consecutive pixel clocks the input has differed from the current output. It moves the output to the input's level only once that run has reached a programmable threshold. The result is a digital low-pass filter: any excursion shorter than the threshold, in either direction, never reaches the output.

The threshold sits in an 8-bit register inside the block. After reset it holds 32. It is rewritten with a one-cycle write strobe. Software is expected to program a value above the widest horizontal sync pulse. The rising and falling decisions each use their own dwell counter. A counter clears as soon as the input returns to the output's level.

Top module: `csync_vsep`

## Requirements
- R1: While `rst_n` is low at a clock edge, `vsync_out` becomes 0, both dwell counters clear and the threshold register takes the value 32. With no write after reset, the output rises at the 33rd consecutive edge that samples `csync_in` high.
- R2: With threshold T, once `csync_in` is sampled high at T+1 consecutive rising edges while `vsync_out` is 0, `vsync_out` becomes 1 right after the last of those edges, and not earlier.
- R3: With threshold T, once `csync_in` is sampled low at T+1 consecutive rising edges while `vsync_out` is 1, `vsync_out` becomes 0 right after the last of those edges, and not earlier.
- R4: An active input pulse that spans at most T edges (a line sync pulse) leaves `vsync_out` at 0.
- R5: A counting run that is broken by even one edge where the input equals the output restarts from zero. A short opposite excursion therefore never changes the output, whether the output is high or low.
- R6: With threshold 0, `vsync_out` equals the value of `csync_in` sampled at the previous rising edge.
- R7: When `thr_we` is 1 at an edge, `thr_wdata` becomes the threshold from the next edge on. The full range 0 to 255 is usable, and 255 needs 256 consecutive edges.
- R8: If the threshold is lowered below a run already counted, the output changes at the first edge that uses the new value. Counters never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csync_in | input | 1 | Composite sync, active high, synchronous to clk |
| thr_we | input | 1 | Threshold register write strobe |
| thr_wdata | input | 8 | New threshold value in pixel clocks |
| vsync_out | output | 1 | Separated vertical sync, active high |

## Verification
The hardest case to reach from the ports is a threshold lowered while a run is already counting past the new value. Only the greater-or-equal comparison saves the counter from wrapping in that case. The stimulus sets a high threshold and holds the input high for part of that count. It then writes a small threshold in the middle of the run, without changing the input. Glitch patterns are laid out with the same care: one-edge returns are placed just before a run would complete, in both the rising and the falling direction.

// File: rtl/csvs_pkg.sv
// Package: shared widths and reset constants for the composite sync separator.
// Assumes a single pixel clock domain for every user.
package csvs_pkg;
    localparam int unsigned THR_W   = 8;
    localparam int unsigned THR_RST = 32;

    typedef logic [THR_W-1:0] thr_t;

    // Index of each dwell counter in the direction array.
    localparam int unsigned DIR_RISE = 0;
    localparam int unsigned DIR_FALL = 1;
    localparam int unsigned DIR_N    = 2;
endpackage

// File: rtl/csvs_thr_reg.sv
// Threshold register: holds the dwell threshold and takes a new value on a write strobe.
// Assumes the writer is synchronous to clk. Reset loads RST_VAL.
module csvs_thr_reg #(
    parameter int unsigned W       = csvs_pkg::THR_W,
    parameter int unsigned RST_VAL = csvs_pkg::THR_RST
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] thr
);
    localparam logic [W-1:0] RST_Q = W'(RST_VAL);

    // Load the default on reset, otherwise capture written data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= RST_Q;
        end else if (we) begin
            thr <= wdata;
        end
    end
endmodule

// File: rtl/csvs_dwell_ctr.sv
// Dwell counter: counts consecutive edges at which `arm` is high.
// It flags `hit` once the count has reached the threshold. The count clears
// whenever arm drops or hit fires. Assumes the owner clears arm after a hit.
// Because the comparison is greater-or-equal, a lowered threshold never lets the count wrap.
module csvs_dwell_ctr #(
    parameter int unsigned W = csvs_pkg::THR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic [W-1:0] thr,
    output logic         hit
);
    logic [W-1:0] cnt;

    // Hit when the run already counted has reached the threshold.
    always_comb begin
        hit = arm && (cnt >= thr);
    end

    // Advance while armed, restart on disarm or completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm || hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/csvs_out_stage.sv
// Output stage: registered vertical sync, set by the rise hit and cleared by the fall hit.
// Assumes the two hits are never high together, which holds because each is armed
// for only one output level.
module csvs_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic set_hit,
    input  logic clr_hit,
    output logic vs
);
    // Move the output level on a completed dwell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs <= 1'b0;
        end else if (set_hit) begin
            vs <= 1'b1;
        end else if (clr_hit) begin
            vs <= 1'b0;
        end
    end
endmodule

// File: rtl/csync_vsep.sv
// Top: separates vertical sync from an active-high composite sync.
// It uses one dwell counter per direction and a programmable threshold register.
// Assumes csync_in is already synchronous to clk.
module csync_vsep (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csync_in,
    input  logic       thr_we,
    input  logic [7:0] thr_wdata,
    output logic       vsync_out
);
    import csvs_pkg::*;

    thr_t              thr_q;
    logic [DIR_N-1:0]  arm;
    logic [DIR_N-1:0]  hit;

    csvs_thr_reg #(.W(THR_W), .RST_VAL(THR_RST)) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (thr_we),
        .wdata (thr_wdata),
        .thr   (thr_q)
    );

    // Arm each direction when the input disagrees with the output that way.
    always_comb begin
        arm[DIR_RISE] = csync_in & ~vsync_out;
        arm[DIR_FALL] = ~csync_in & vsync_out;
    end

    for (genvar gi = 0; gi < DIR_N; gi++) begin : g_dir
        csvs_dwell_ctr #(.W(THR_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (arm[gi]),
            .thr   (thr_q),
            .hit   (hit[gi])
        );
    end

    csvs_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_hit (hit[DIR_RISE]),
        .clr_hit (hit[DIR_FALL]),
        .vs      (vsync_out)
    );
endmodule

// File: rtl/csvs_checker.sv
// Checker: temporal properties of the separator, bound into csync_vsep.
// It keeps its own count of the mismatch run to check the dwell windows.
module csvs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_in,
    input logic       vs_out,
    input logic [7:0] thr
);
    logic [8:0] run;

    // Count consecutive edges where the input differs from the output.
    always_ff @(posedge clk) begin
        if (!rst_n || (sync_in == vs_out)) begin
            run <= '0;
        end else if (run != 9'h1FF) begin
            run <= run + 1'b1;
        end
    end

    p_reset_out_r1: assert property (@(posedge clk) !rst_n |=> !vs_out);
    p_reset_thr_r1: assert property (@(posedge clk) !rst_n |=> (thr == 8'd32));

    // R2/R3: a completed run moves the output to the input level.
    p_change_at_dwell_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync_in != vs_out) && (run >= {1'b0, thr})) |=> (vs_out == $past(sync_in)));
    // R4: an incomplete run holds the output.
    p_hold_before_dwell_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync_in != vs_out) && (run < {1'b0, thr})) |=> $stable(vs_out));
    // R5: agreement never moves the output.
    p_hold_when_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in == vs_out) |=> $stable(vs_out));
    // R6: a zero threshold gives a one-cycle follower.
    p_zero_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == 8'd0) |=> (vs_out == $past(sync_in)));
endmodule

bind csync_vsep csvs_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (csync_in),
    .vs_out  (vsync_out),
    .thr     (thr_q)
);

// File: tb/csync_vsep_tb_top.sv
// Scoreboard bench: the driver models the requirements and queues the expected output.
// The monitor compares one item per clock, just after each edge.
module csync_vsep_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csync_in = 1'b0;
    logic       thr_we = 1'b0;
    logic [7:0] thr_wdata = 8'd0;
    logic       vsync_out;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t sbq[$];

    // Bench model state, written from the requirements.
    logic  m_out = 1'b0;
    int    m_run = 0;
    int    m_thr = 32;
    string cur_tag = "R1";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    csync_vsep dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .csync_in  (csync_in),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .vsync_out (vsync_out)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: vsync_out=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One driven clock: set inputs at the falling edge, queue the expected output.
    task automatic drive_cycle(input logic v, input bit we, input int wd);
        @(negedge clk);
        csync_in  = v;
        thr_we    = we;
        thr_wdata = 8'(wd);
        if (v != m_out) begin
            if (m_run >= m_thr) begin
                m_out = v;
                m_run = 0;
            end else begin
                m_run++;
            end
        end else begin
            m_run = 0;
        end
        if (we) m_thr = wd;
        sbq.push_back('{exp: m_out, tag: cur_tag});
    endtask

    task automatic hold(input logic v, input int n);
        for (int i = 0; i < n; i++) drive_cycle(v, 1'b0, 0);
    endtask

    task automatic set_thr(input int t);
        drive_cycle(csync_in, 1'b1, t);
        drive_cycle(csync_in, 1'b0, 0);
    endtask

    // Monitor: compare the queued expectation just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() != 0) begin
                item_t it;
                it = sbq.pop_front();
                check(vsync_out, it.exp, it.tag);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(vsync_out, 1'b0, "R1 reset");
        rst_n = 1'b1;
        // R1: the default threshold of 32 needs 33 edges.
        cur_tag = "R1";
        hold(1'b1, 32);
        hold(1'b1, 3);
        cur_tag = "R3";
        hold(1'b0, 40);
        // R4: line sync pulses narrower than the threshold.
        cur_tag = "R4";
        for (int l = 0; l < 6; l++) begin
            hold(1'b1, 20 + l * 2);
            hold(1'b0, 60);
        end
        hold(1'b1, 32);
        hold(1'b0, 10);
        // R7: a smaller threshold, then R2/R3 exact edges.
        cur_tag = "R7";
        set_thr(5);
        cur_tag = "R2";
        hold(1'b1, 5);
        hold(1'b1, 4);
        cur_tag = "R3";
        hold(1'b0, 5);
        hold(1'b0, 4);
        // R5: one-edge returns just before completion, both directions.
        cur_tag = "R5";
        hold(1'b1, 5); hold(1'b0, 1); hold(1'b1, 5); hold(1'b0, 1); hold(1'b1, 8);
        hold(1'b0, 5); hold(1'b1, 1); hold(1'b0, 5); hold(1'b1, 2); hold(1'b0, 8);
        // R6: zero threshold follows with one edge of delay.
        cur_tag = "R6";
        set_thr(0);
        for (int i = 0; i < 40; i++) hold(((i * 7) % 5) > 1, 1 + (i % 3));
        hold(1'b0, 3);
        // R7: the largest threshold needs 256 edges.
        cur_tag = "R7";
        set_thr(255);
        hold(1'b1, 255);
        hold(1'b1, 3);
        hold(1'b0, 258);
        // R8: lower the threshold below an ongoing run.
        cur_tag = "R8";
        set_thr(100);
        hold(1'b1, 50);
        drive_cycle(1'b1, 1'b1, 10);
        hold(1'b1, 5);
        hold(1'b0, 30);
        drive_cycle(1'b0, 1'b1, 200);
        hold(1'b0, 5);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule